// File: doc/BRIEF.md
# Periodic Tick Timer with Missed-Period Accounting

The block produces a periodic tick for a processor. Software programs a period, turns the counter on, and optionally turns on the interrupt. While it is on, a free-running count rises by one on every clock. When the count has reached the programmed period, the next clock returns it to zero. Each of these reloads raises a pending flag and adds one to a wrap tally.

Interrupt service can be late, so the wrap tally records how many periods passed since the last acknowledge. Software can then account for every period, even if it missed several.

There are two read views of the count and the tally. The snapshot view leaves all state alone. The acknowledge view returns the same word and then clears both the tally and the pending flag. The interrupt output is a level. Because the line may be shared, software reads the pending flag before it claims the interrupt.

The register port is a plain single-cycle strobe interface. Reads are combinational in the cycle of the strobe, and writes take effect at the closing clock edge. It carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `pit_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Counter stepping:
  - While enabled, the count (bits 19:0 of the count views) rises by one per clock.
  - On the clock after it equals the period, the count returns to zero, so one period lasts period+1 clocks.
  - A period of zero reloads on every clock.
- R3: Every reload adds one to the wrap tally (bits 31:20 of the count views) and sets the pending flag (bit 0 at address 1).
- R4: The wrap tally stops at 4095 and does not roll over.
- R5: Acknowledge read (address 2):
  - It returns {tally, count}.
  - At the closing edge of the read it clears the tally and the pending flag.
  - If a reload falls on that same edge, the tally becomes 1 and the flag stays set.
- R6: A snapshot read (address 3) returns {tally, count} and changes nothing.
- R7: `irq` is high exactly while the pending flag and the interrupt-enable bit (bit 25 of the mode register) are both set.
- R8: Disable behaviour:
  - Clearing the count-enable bit (bit 24 of the mode register) zeroes the count, the tally and the pending flag from the following clock onward.
  - Writing all zeros to the mode register stops both counting and interrupts.
- R9: Register map and writes:
  - The mode register at address 0 reads back as {6'b0, irq enable, count enable, 4'b0, period[19:0]}.
  - Writes to addresses 1, 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 mode, 1 status, 2 acknowledge, 3 snapshot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Level interrupt request |

## Verification
The timer is run with three periods:
- A ten-clock period shows the count stepping and two wraps collecting before service. It also shows that gating `irq` changes only the interrupt.
- A four-clock period, read at several offsets, tells an off-by-one reload apart from a correct one.
- A zero period wraps on every clock. This drives the tally into saturation and shows whether it stops at its limit instead of rolling over.

An acknowledge placed exactly on a reload edge separates a design that drops that period from one that keeps it. Writes to the read-only addresses, followed by snapshot reads, show that those writes do not disturb the state.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 20;
  localparam int WRAP_W  = 12;
  localparam int EN_BIT  = 24;
  localparam int IE_BIT  = 25;

  typedef enum logic [1:0] {
    REG_MODE   = 2'd0,
    REG_STATUS = 2'd1,
    REG_ACK    = 2'd2,
    REG_SNAP   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pit_period_counter.sv
module pit_period_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             reload
);
  // A shortened period can leave the count above the limit, so the compare is >=.
  assign reload = en && (cnt >= period);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (reload) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pit_wrap_accum.sv
module pit_wrap_accum #(
  parameter int WRAP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              reload,
  input  logic              ack,
  output logic [WRAP_W-1:0] wrap,
  output logic              pend
);
  localparam logic [WRAP_W-1:0] WRAP_MAX = {WRAP_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrap <= '0;
      pend <= 1'b0;
    end else if (!en) begin
      wrap <= '0;
      pend <= 1'b0;
    end else if (ack) begin
      // A reload on the acknowledge edge is kept as the first new period.
      wrap <= reload ? {{(WRAP_W-1){1'b0}}, 1'b1} : '0;
      pend <= reload;
    end else if (reload) begin
      if (wrap != WRAP_MAX) wrap <= wrap + 1'b1;
      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/pit_regfile.sv
module pit_regfile
  import pit_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int WRAP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cur_cnt,
  input  logic [WRAP_W-1:0] wrap_cnt,
  input  logic              pend,
  output logic [CNT_W-1:0]  period,
  output logic              mode_en,
  output logic              mode_ie,
  output logic              ack_rd,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int PAD_W = DATA_W - CNT_W - WRAP_W;

  logic              mode_wr;
  logic [DATA_W-1:0] mode_word;
  logic [DATA_W-1:0] count_word;

  assign mode_wr = bus_sel && bus_wr && (reg_sel_e'(bus_addr) == REG_MODE);
  assign ack_rd  = bus_sel && !bus_wr && (reg_sel_e'(bus_addr) == REG_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period  <= '0;
      mode_en <= 1'b0;
      mode_ie <= 1'b0;
    end else if (mode_wr) begin
      period  <= bus_wdata[CNT_W-1:0];
      mode_en <= bus_wdata[EN_BIT];
      mode_ie <= bus_wdata[IE_BIT];
    end
  end

  always_comb begin
    mode_word               = '0;
    mode_word[CNT_W-1:0]    = period;
    mode_word[EN_BIT]       = mode_en;
    mode_word[IE_BIT]       = mode_ie;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign count_word = {wrap_cnt, {PAD_W{1'b0}}, cur_cnt};
    end else begin : g_nopad
      assign count_word = {wrap_cnt, cur_cnt};
    end
  endgenerate

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      REG_MODE:   bus_rdata = mode_word;
      REG_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, pend};
      REG_ACK:    bus_rdata = count_word;
      REG_SNAP:   bus_rdata = count_word;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W  = pit_pkg::CNT_W,
  parameter int WRAP_W = pit_pkg::WRAP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [CNT_W-1:0]  period;
  logic              mode_en;
  logic              mode_ie;
  logic              ack_rd;
  logic [CNT_W-1:0]  cur_cnt;
  logic              reload;
  logic [WRAP_W-1:0] wrap_cnt;
  logic              pend;

  pit_regfile #(.CNT_W(CNT_W), .WRAP_W(WRAP_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cur_cnt(cur_cnt), .wrap_cnt(wrap_cnt), .pend(pend),
    .period(period), .mode_en(mode_en), .mode_ie(mode_ie),
    .ack_rd(ack_rd), .bus_rdata(bus_rdata)
  );

  pit_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(mode_en), .period(period),
    .cnt(cur_cnt), .reload(reload)
  );

  pit_wrap_accum #(.WRAP_W(WRAP_W)) u_wrap (
    .clk(clk), .rst_n(rst_n), .en(mode_en), .reload(reload), .ack(ack_rd),
    .wrap(wrap_cnt), .pend(pend)
  );

  assign irq = pend && mode_ie;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int CNT_W  = 20,
  parameter int WRAP_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              irq_en,
  input logic [CNT_W-1:0]  cnt,
  input logic [WRAP_W-1:0] wrap,
  input logic              status,
  input logic              ack,
  input logic              irq
);
  localparam logic [WRAP_W-1:0] WRAP_MAX = {WRAP_W{1'b1}};

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && cnt != '0) |-> (cnt == $past(cnt) + 1'b1));

  p_wrap_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap != '0) |-> status);

  p_wrap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ack && wrap == WRAP_MAX) |=> (wrap == WRAP_MAX));

  p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (wrap <= 1));

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status && irq_en));

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  p_disable_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && wrap == '0 && !status));
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W), .WRAP_W(WRAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(mode_en), .irq_en(mode_ie),
  .cnt(cur_cnt), .wrap(wrap_cnt), .status(pend), .ack(ack_rd), .irq(irq)
);

// File: tb/sim_pit_timer.sv
module sim_pit_timer;
  import pit_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #5 clk = ~clk;

  pit_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference state derived from the requirements.
  bit m_en = 0;
  bit m_ie = 0;
  int m_p = 0;
  int t_en = 0;
  int base = 0;

  typedef struct {
    logic [31:0] data;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic model_fields(output int c, output int w, output int k);
    if (!m_en) begin
      c = 0; w = 0; k = 0;
    end else begin
      k = cyc - t_en;
      c = k % (m_p + 1);
      w = k / (m_p + 1) - base;
      if (w > 4095) w = 4095;
    end
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    int c, w, k;
    exp_t e;
    @(posedge clk); #1;
    model_fields(c, w, k);
    case (a)
      2'd0:    e.data = {6'b0, m_ie, m_en, 4'b0, m_p[19:0]};
      2'd1:    e.data = {31'b0, (w > 0)};
      default: e.data = {w[11:0], c[19:0]};
    endcase
    e.irq = (w > 0) && m_ie && m_en;
    e.tag = tag;
    sb.push_back(e);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    if (a == 2'd2 && m_en) base = k / (m_p + 1);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (a == 2'd0) begin
      if (d[EN_BIT] && !m_en) begin
        t_en = cyc;
        base = 0;
      end
      m_en = d[EN_BIT];
      m_ie = d[IE_BIT];
      m_p  = int'(d[19:0]);
    end
  endtask

  function automatic logic [31:0] mode_val(input bit ie, input bit en, input int p);
    logic [31:0] v;
    v = '0;
    v[19:0] = p[19:0];
    v[EN_BIT] = en;
    v[IE_BIT] = ie;
    return v;
  endfunction

  // Monitor: compares each read against the head of the scoreboard.
  always @(negedge clk) begin
    if (bus_sel && !bus_wr) begin
      exp_t e;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expected entry, actual %h", bus_rdata);
      end else begin
        e = sb.pop_front();
        checks++;
        if (bus_rdata !== e.data || irq !== e.irq) begin
          errors++;
          $display("FAIL %s: actual data=%h irq=%b expected data=%h irq=%b",
                   e.tag, bus_rdata, irq, e.data, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(2'd0, "R1 mode after reset");
    rd(2'd1, "R1 status after reset");
    rd(2'd3, "R1 snapshot after reset");

    // R2, R9: period 9, counting, interrupts gated off
    wr(2'd0, mode_val(0, 1, 9));
    rd(2'd0, "R9 mode readback");
    rd(2'd3, "R2 count step a");
    repeat (3) @(posedge clk);
    rd(2'd3, "R2 count step b");

    // R3, R6, R7: let two periods pass without service
    repeat (20) @(posedge clk);
    rd(2'd1, "R3 pending after wraps");
    rd(2'd3, "R6 snapshot first");
    rd(2'd3, "R6 snapshot second unchanged tally");

    // R5: acknowledge then observe cleared tally
    rd(2'd2, "R5 ack returns fields");
    rd(2'd3, "R5 tally after ack");
    rd(2'd1, "R5 status after ack");

    // R9: writes to read-only views have no effect
    repeat (25) @(posedge clk);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd1, 32'h0000_0000);
    rd(2'd3, "R9 snapshot after ignored writes");
    rd(2'd1, "R9 status after ignored writes");

    // R7: enable interrupt on a running timer
    wr(2'd0, mode_val(1, 1, 9));
    rd(2'd1, "R7 irq with pending and enable");
    rd(2'd2, "R7 ack for irq drop");
    rd(2'd3, "R7 irq after ack");

    // R5: acknowledge landing on a reload edge
    do begin @(posedge clk); #1; end while (((cyc + 1 - t_en) % (m_p + 1)) != m_p);
    rd(2'd2, "R5 ack on reload edge");
    rd(2'd3, "R5 tally kept on collision");
    rd(2'd1, "R5 pending kept on collision");

    // R8: disable clears everything
    wr(2'd0, 32'h0);
    repeat (3) @(posedge clk);
    rd(2'd3, "R8 snapshot after disable");
    rd(2'd1, "R8 status after disable");
    repeat (4) @(posedge clk);
    rd(2'd3, "R8 count held while disabled");

    // R2: period 3 at several offsets
    wr(2'd0, mode_val(0, 1, 3));
    for (int i = 0; i < 6; i++) rd(2'd3, "R2 period three offsets");

    // R4: zero period wraps each clock; tally saturates
    wr(2'd0, 32'h0);
    repeat (2) @(posedge clk);
    wr(2'd0, mode_val(1, 1, 0));
    rd(2'd3, "R2 zero period");
    repeat (4300) @(posedge clk);
    rd(2'd3, "R4 tally saturated");
    rd(2'd3, "R4 tally stays saturated");
    rd(2'd2, "R4 ack of saturated tally");
    rd(2'd3, "R4 tally restarts after ack");

    // R8: all-zero write stops interrupt
    wr(2'd0, 32'h0);
    repeat (2) @(posedge clk);
    rd(2'd1, "R8 all zero mode stops irq");

    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule